// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block derives the SPI serial clock pin from a fast reference clock. It does not use an integer divider. A phase accumulator of 2048 steps per SCK period advances by a frequency word on every reference cycle. The pin takes its level from the upper half of the phase circle. For a reference-to-SCK ratio of N, software programs the word to ceiling(2048 / N). Ratios that do not divide 2048 then give an average SCK rate with cycle-to-cycle jitter of one reference period.

The transfer engine raises `run` for the duration of a transfer. While `run` is low, the pin rests at the level chosen by `cpol`. The accumulator either keeps its phase or, when `loop_rst_en` is set, returns to zero so that every transfer starts from the same phase. Two single-cycle strobes, `sck_rise` and `sck_fall`, accompany every pin transition. The engine uses them to launch and latch data. `gate_en` acts as a clock enable for the whole block. Reset is applied asynchronously and released through a two-stage synchronizer.

Top module: `frac_sck_gen`

## Requirements
- R1: While reset is asserted, `sck`, `sck_rise` and `sck_fall` are all 0, and the phase is 0.
- R2: On each reference edge with `gate_en`=1 and `run`=1, the phase advances by the effective word modulo 2048. Right after that edge, `sck` equals `cpol` XOR (phase >= 1024). A word of 2048/N for N a power of two therefore gives an SCK period of exactly N reference cycles.
- R3: A frequency word above 1024 has the same effect as 1024. `sck` then toggles on every running edge.
- R4: A frequency word of 0 leaves the phase unchanged, so `sck` stays constant while running.
- R5: On an edge with `gate_en`=1, `run`=0 and `loop_rst_en`=0, `sck` becomes `cpol` and the phase is kept. Running later continues from that phase.
- R6: On an edge with `gate_en`=1, `run`=0 and `loop_rst_en`=1, `sck` becomes `cpol` and the phase is cleared to 0. The first transition away from idle then comes after ceiling(1024/word) running edges.
- R7: `sck_rise` is 1 for exactly the one cycle after an edge that took `sck` from 0 to 1. `sck_fall` does the same for 1 to 0. The two are never 1 together.
- R8: On an edge with `gate_en`=0, phase and `sck` hold their values and both strobes are 0, whatever `run` is.
- R9: With `cpol`=1 the idle level is 1, and the first transition of a transfer starting from phase 0 is a falling one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| freq_word | input | 14 | Phase increment per reference cycle (2048 = one SCK period) |
| loop_rst_en | input | 1 | Clear the phase while not running |
| cpol | input | 1 | Idle level of SCK |
| gate_en | input | 1 | Block clock enable |
| run | input | 1 | Transfer active, from the transfer engine |
| sck | output | 1 | Serial clock pin level |
| sck_rise | output | 1 | One-cycle strobe after a 0-to-1 pin transition |
| sck_fall | output | 1 | One-cycle strobe after a 1-to-0 pin transition |

## Verification
A wrong phase value never shows on a port by itself. It appears as an SCK transition one or more reference cycles early or late, at most 1024/word cycles after the fault. A fault in the loop clear or the hold only shows at the next transfer start. A fault in the strobe logic shows in the same cycle as the pin transition it should mark. The bench therefore compares all three outputs every cycle against a phase model, across restarts, gating and word changes, so a drift is caught at the first edge it moves.

// File: rtl/fsg_pkg.sv
`timescale 1ns/1ps
package fsg_pkg;
  localparam int FSG_WORD_W = 14;
  localparam int FSG_ACC_W  = 11;

  typedef struct packed {
    logic sck;
    logic rise;
    logic fall;
  } fsg_pin_t;
endpackage

// File: rtl/fsg_rst_sync.sv
`timescale 1ns/1ps
module fsg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/fsg_word_clamp.sv
`timescale 1ns/1ps
module fsg_word_clamp #(
  parameter int WORD_W = 14,
  parameter int ACC_W  = 11
) (
  input  logic [WORD_W-1:0] word,
  output logic [ACC_W-1:0]  step
);
  localparam int HALF = 1 << (ACC_W - 1);
  localparam logic [WORD_W-1:0] HALF_W = WORD_W'(HALF);
  localparam logic [ACC_W-1:0]  HALF_A = ACC_W'(HALF);

  always_comb begin
    if (word > HALF_W) step = HALF_A;
    else               step = word[ACC_W-1:0];
  end
endmodule

// File: rtl/fsg_phase_accum.sv
`timescale 1ns/1ps
module fsg_phase_accum #(
  parameter int ACC_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             run,
  input  logic             clr_en,
  input  logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] acc,
  output logic             phase_nxt
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;

  always_comb begin
    acc_d = acc_q;
    if (ce) begin
      if (run)         acc_d = acc_q + step;
      else if (clr_en) acc_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc       = acc_q;
  assign phase_nxt = acc_d[ACC_W-1];

  AST_ZERO_STEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && run && step == '0) |=> $stable(acc_q)); // R4
  AST_IDLE_KEEPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !run && !clr_en) |=> $stable(acc_q)); // R5
  AST_LOOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !run && clr_en) |=> (acc_q == '0)); // R6
  AST_GATED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/fsg_pin_edge.sv
`timescale 1ns/1ps
module fsg_pin_edge
  import fsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic run,
  input  logic cpol,
  input  logic phase_nxt,
  output logic sck,
  output logic rise,
  output logic fall
);
  fsg_pin_t pin_q;
  fsg_pin_t pin_d;
  logic     level;

  always_comb begin
    level      = run ? (cpol ^ phase_nxt) : cpol;
    pin_d      = pin_q;
    pin_d.rise = 1'b0;
    pin_d.fall = 1'b0;
    if (ce) begin
      pin_d.sck  = level;
      pin_d.rise = !pin_q.sck && level;
      pin_d.fall = pin_q.sck && !level;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign sck  = pin_q.sck;
  assign rise = pin_q.rise;
  assign fall = pin_q.fall;

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise && fall)); // R7
  AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !sck) |=> (rise == sck)); // R7
  AST_FALL_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && sck) |=> (fall == !sck)); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !run) |=> (sck == $past(cpol))); // R5
  AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> ($stable(sck) && !rise && !fall)); // R8
endmodule

// File: rtl/frac_sck_gen.sv
`timescale 1ns/1ps
module frac_sck_gen
  import fsg_pkg::*;
#(
  parameter int WORD_W = FSG_WORD_W,
  parameter int ACC_W  = FSG_ACC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] freq_word,
  input  logic              loop_rst_en,
  input  logic              cpol,
  input  logic              gate_en,
  input  logic              run,
  output logic              sck,
  output logic              sck_rise,
  output logic              sck_fall
);
  localparam int HALF = 1 << (ACC_W - 1);

  logic             rst_sync_n;
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] acc;
  logic             phase_nxt;

  fsg_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsg_word_clamp #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_clamp (
    .word (freq_word),
    .step (step)
  );

  fsg_phase_accum #(.ACC_W(ACC_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ce        (gate_en),
    .run       (run),
    .clr_en    (loop_rst_en),
    .step      (step),
    .acc       (acc),
    .phase_nxt (phase_nxt)
  );

  fsg_pin_edge u_pin (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ce        (gate_en),
    .run       (run),
    .cpol      (cpol),
    .phase_nxt (phase_nxt),
    .sck       (sck),
    .rise      (sck_rise),
    .fall      (sck_fall)
  );

  AST_STEP_CAPPED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(step) <= HALF)); // R3
  AST_PIN_TRACKS_PHASE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (gate_en && run) |=> (sck == ($past(cpol) ^ acc[ACC_W-1]))); // R2
endmodule

// File: tb/sim_frac_sck_gen.sv
`timescale 1ns/1ps
module sim_frac_sck_gen;
  logic        clk;
  logic        rst_n;
  logic [13:0] freq_word;
  logic        loop_rst_en;
  logic        cpol;
  logic        gate_en;
  logic        run;
  logic        sck;
  logic        sck_rise;
  logic        sck_fall;

  typedef struct {
    logic  sck;
    logic  rise;
    logic  fall;
    string tag;
  } exp_t;

  exp_t sb[$];
  exp_t mon_item;
  int   checks;
  int   failures;
  bit   done;
  int   m_acc;
  logic m_sck;

  frac_sck_gen u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .freq_word   (freq_word),
    .loop_rst_en (loop_rst_en),
    .cpol        (cpol),
    .gate_en     (gate_en),
    .run         (run),
    .sck         (sck),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic drive(input logic [13:0] w, input logic lre, input logic cp,
                       input logic g, input logic r, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      int   eff;
      logic nsck;
      @(negedge clk);
      freq_word   = w;
      loop_rst_en = lre;
      cpol        = cp;
      gate_en     = g;
      run         = r;
      eff = (int'(w) > 1024) ? 1024 : int'(w);
      e.tag  = tag;
      e.rise = 1'b0;
      e.fall = 1'b0;
      if (g) begin
        if (r) begin
          m_acc = (m_acc + eff) % 2048;
          nsck  = cp ^ (m_acc >= 1024);
        end else begin
          if (lre) m_acc = 0;
          nsck = cp;
        end
        e.rise = !m_sck && nsck;
        e.fall = m_sck && !nsck;
        m_sck  = nsck;
      end
      e.sck = m_sck;
      sb.push_back(e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        mon_item = sb.pop_front();
        checks++;
        if (sck !== mon_item.sck || sck_rise !== mon_item.rise || sck_fall !== mon_item.fall) begin
          failures++;
          $display("FAIL %s sck/rise/fall got %b%b%b expected %b%b%b at %0t",
                   mon_item.tag, sck, sck_rise, sck_fall,
                   mon_item.sck, mon_item.rise, mon_item.fall, $time);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired, run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    m_acc = 0; m_sck = 1'b0;
    rst_n = 1'b0; freq_word = '0; loop_rst_en = 1'b0;
    cpol = 1'b0; gate_en = 1'b0; run = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (sck !== 1'b0) begin failures++; $display("FAIL R1 sck got %b expected 0", sck); end
    checks++;
    if (sck_rise !== 1'b0) begin failures++; $display("FAIL R1 sck_rise got %b expected 0", sck_rise); end
    checks++;
    if (sck_fall !== 1'b0) begin failures++; $display("FAIL R1 sck_fall got %b expected 0", sck_fall); end
    rst_n = 1'b1;
    // R8: gated while the reset release settles; state must stay at 0
    drive(14'd256, 1'b0, 1'b0, 1'b0, 1'b1, 4, "R1 R8 gated after reset");
    // R2, R7: exact ratios and a fractional one
    drive(14'd256,  1'b0, 1'b0, 1'b1, 1'b1, 40, "R2 R7 ratio 8");
    drive(14'd512,  1'b0, 1'b0, 1'b1, 1'b1, 20, "R2 R7 ratio 4");
    drive(14'd171,  1'b0, 1'b0, 1'b1, 1'b1, 60, "R2 R7 ratio 12");
    // R3: saturation of large words
    drive(14'd2000, 1'b0, 1'b0, 1'b1, 1'b1, 10, "R3 word 2000");
    drive(14'd16383,1'b0, 1'b0, 1'b1, 1'b1, 6,  "R3 word max");
    drive(14'd1024, 1'b0, 1'b0, 1'b1, 1'b1, 6,  "R3 word 1024");
    // R4: zero word stops the clock
    drive(14'd0,    1'b0, 1'b0, 1'b1, 1'b1, 10, "R4 zero word");
    // R5: idle without loop reset keeps the phase
    drive(14'd100,  1'b0, 1'b0, 1'b1, 1'b1, 7,  "R5 pre-idle");
    drive(14'd100,  1'b0, 1'b0, 1'b1, 1'b0, 5,  "R5 idle hold");
    drive(14'd100,  1'b0, 1'b0, 1'b1, 1'b1, 30, "R5 resume");
    // R6: idle with loop reset clears the phase
    drive(14'd300,  1'b1, 1'b0, 1'b1, 1'b0, 4,  "R6 idle clear");
    drive(14'd300,  1'b1, 1'b0, 1'b1, 1'b1, 20, "R6 restart");
    // R8: gate low freezes everything, run or not
    drive(14'd300,  1'b0, 1'b0, 1'b0, 1'b1, 8,  "R8 gated run");
    drive(14'd300,  1'b1, 1'b1, 1'b0, 1'b0, 4,  "R8 gated idle");
    drive(14'd300,  1'b0, 1'b0, 1'b1, 1'b1, 10, "R8 ungated");
    // R9: inverted polarity
    drive(14'd200,  1'b1, 1'b1, 1'b1, 1'b0, 3,  "R9 idle high");
    drive(14'd200,  1'b1, 1'b1, 1'b1, 1'b1, 30, "R9 R7 run high idle");
    drive(14'd200,  1'b0, 1'b1, 1'b1, 1'b0, 3,  "R9 R5 return to idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule